// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the low-order word-address bits of a four-beat memory burst. When the surrounding logic captures a new external address, it pulses a load strobe and presents the starting low bits. The generator latches them and clears its internal beat count. After that, each clock edge on which the active-low advance input is low moves the burst to the next beat. Each edge on which advance is high is a wait cycle: the address stays where it is.

A static order-select input picks one of two sequences. Linear order adds the beat number to the start value and wraps around the top of the range. Interleaved order combines the start value and the beat number with a bitwise XOR. The bits are meant to be joined with upper address bits that are held outside this block. The width of the sequence is a parameter. It defaults to two bits, which gives four beats.

Top module: `burst_seq_gen`

## Requirements
- R1: While reset is asserted, and after reset is released until the first load or advance, `addr_o` and `beat_o` are both 0.
- R2: A rising clock edge with `load_i`=1 makes `beat_o`=0 and `addr_o`=`start_i` (the value sampled at that edge), in either order mode.
- R3: A rising clock edge with `load_i`=0 and `adv_ni`=0 increments `beat_o` by one, modulo 4.
- R4: A rising clock edge with `load_i`=0 and `adv_ni`=1 leaves `beat_o` and `addr_o` unchanged (wait cycle).
- R5: With `ilv_i`=0 (linear order), `addr_o` = (start + `beat_o`) mod 4. For example, a start of 3 gives 3, 0, 1, 2.
- R6: With `ilv_i`=1 (interleaved order), `addr_o` = start XOR `beat_o`. For example, a start of 2 gives 2, 3, 0, 1.
- R7: When `load_i`=1 and `adv_ni`=0 at the same edge, the load wins: `beat_o` becomes 0 and `addr_o` becomes the new start.
- R8: After four advances from a load, `beat_o` returns to 0 and `addr_o` returns to the start value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Load strobe: capture a new start value, active high |
| start_i | input | SEQ_W | Starting low-order address bits |
| adv_ni | input | 1 | Advance, active low; high means wait |
| ilv_i | input | 1 | Order select: 0 linear, 1 interleaved (held static during a burst) |
| addr_o | output | SEQ_W | Current low-order address bits |
| beat_o | output | SEQ_W | Beat index within the burst |

## Verification
The block holds only two registers, the latched start and the beat count. Both of them appear at the ports in the same cycle they change. A wrong beat count therefore shows up on `beat_o` one edge after the faulty load or advance. It also corrupts `addr_o` in that same cycle in both orders. A corrupted start value shows on `addr_o` right after the load and stays wrong for the whole burst. The directed runs sweep every start value in both orders, including the wrap and the load-over-advance collision. Every fault surfaces within one clock of its cause.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
   // Encoding of the order-select pin
   typedef enum logic {
      ORD_LINEAR = 1'b0,
      ORD_XOR    = 1'b1
   } order_e;

   localparam int SEQ_W_MIN = 1;
   localparam int SEQ_W_MAX = 4;
endpackage

// File: rtl/burst_ptr_reg.sv
// Holds the latched start value and the beat count of the current burst.
module burst_ptr_reg #(
   parameter int SEQ_W = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             load_i,
   input  logic             adv_ni,
   input  logic [SEQ_W-1:0] start_i,
   output logic [SEQ_W-1:0] base_o,
   output logic [SEQ_W-1:0] beat_o
);
   localparam logic [SEQ_W-1:0] ONE = SEQ_W'(1);

   logic [SEQ_W-1:0] base_q;
   logic [SEQ_W-1:0] beat_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         base_q <= '0;
         beat_q <= '0;
      end else if (load_i) begin
         // a load outranks a simultaneous advance
         base_q <= start_i;
         beat_q <= '0;
      end else if (!adv_ni) begin
         beat_q <= beat_q + ONE;
      end
   end

   assign base_o = base_q;
   assign beat_o = beat_q;
endmodule

// File: rtl/burst_order_map.sv
// Maps (start, beat) to the issued address in either order.
module burst_order_map
   import burst_seq_pkg::*;
#(
   parameter int SEQ_W = 2
) (
   input  logic             ilv_i,
   input  logic [SEQ_W-1:0] base_i,
   input  logic [SEQ_W-1:0] beat_i,
   output logic [SEQ_W-1:0] addr_o
);
   logic [SEQ_W-1:0] lin_addr;
   logic [SEQ_W-1:0] xor_addr;
   order_e           order;

   assign order    = order_e'(ilv_i);
   assign lin_addr = base_i + beat_i;   // wraps at 2**SEQ_W

   for (genvar b = 0; b < SEQ_W; b++) begin : g_xor_bit
      assign xor_addr[b] = base_i[b] ^ beat_i[b];
   end

   always_comb begin
      if (order == ORD_XOR) addr_o = xor_addr;
      else                  addr_o = lin_addr;
   end
endmodule

// File: rtl/burst_seq_gen.sv
module burst_seq_gen
   import burst_seq_pkg::*;
#(
   parameter int SEQ_W = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             load_i,
   input  logic [SEQ_W-1:0] start_i,
   input  logic             adv_ni,
   input  logic             ilv_i,
   output logic [SEQ_W-1:0] addr_o,
   output logic [SEQ_W-1:0] beat_o
);
   if (SEQ_W < SEQ_W_MIN || SEQ_W > SEQ_W_MAX) begin : g_bad_width
      $error("burst_seq_gen: SEQ_W out of supported range");
   end

   logic [SEQ_W-1:0] base;
   logic [SEQ_W-1:0] beat;

   burst_ptr_reg #(.SEQ_W(SEQ_W)) u_ptr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (load_i),
      .adv_ni  (adv_ni),
      .start_i (start_i),
      .base_o  (base),
      .beat_o  (beat)
   );

   burst_order_map #(.SEQ_W(SEQ_W)) u_map (
      .ilv_i  (ilv_i),
      .base_i (base),
      .beat_i (beat),
      .addr_o (addr_o)
   );

   assign beat_o = beat;
endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk #(
   parameter int SEQ_W = 2
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             load_i,
   input logic [SEQ_W-1:0] start_i,
   input logic             adv_ni,
   input logic             ilv_i,
   input logic [SEQ_W-1:0] addr_o,
   input logic [SEQ_W-1:0] beat_o
);
   // shadow of the most recent start value, seen at the ports only
   logic [SEQ_W-1:0] st_q;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     st_q <= '0;
      else if (load_i) st_q <= start_i;
   end

   p_reset_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(rst_ni) |-> (addr_o == '0 && beat_o == '0));

   // R2 and R7: a load clears the beat and exposes the start, advance or not
   p_load_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_i |=> (beat_o == '0 && addr_o == $past(start_i)));

   p_advance_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!load_i && !adv_ni) |=> beat_o == SEQ_W'($past(beat_o) + 1'b1));

   p_wait_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!load_i && adv_ni) |=> ($stable(beat_o) && (!$stable(ilv_i) || $stable(addr_o))));

   p_linear_order_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ilv_i |-> addr_o == SEQ_W'(st_q + beat_o));

   p_xor_order_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ilv_i |-> addr_o == (st_q ^ beat_o));
endmodule

bind burst_seq_gen burst_seq_chk #(.SEQ_W(SEQ_W)) u_chk (
   .clk_i   (clk_i),
   .rst_ni  (rst_ni),
   .load_i  (load_i),
   .start_i (start_i),
   .adv_ni  (adv_ni),
   .ilv_i   (ilv_i),
   .addr_o  (addr_o),
   .beat_o  (beat_o)
);

// File: tb/tb_burst_seq_gen.sv
`timescale 1ns/1ps
module tb_burst_seq_gen;
   localparam int W = 2;

   logic         clk = 1'b0;
   logic         rst_ni = 1'b0;
   logic         load_i = 1'b0;
   logic [W-1:0] start_i = '0;
   logic         adv_ni = 1'b1;
   logic         ilv_i = 1'b0;
   logic [W-1:0] addr_o;
   logic [W-1:0] beat_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   burst_seq_gen #(.SEQ_W(W)) dut (
      .clk_i(clk), .rst_ni(rst_ni), .load_i(load_i), .start_i(start_i),
      .adv_ni(adv_ni), .ilv_i(ilv_i), .addr_o(addr_o), .beat_o(beat_o)
   );

   task automatic check(string tag, logic [W-1:0] ea, logic [W-1:0] eb);
      checks++;
      if (addr_o !== ea || beat_o !== eb) begin
         errors++;
         $display("FAIL %s: addr=%0d beat=%0d expected addr=%0d beat=%0d",
                  tag, addr_o, beat_o, ea, eb);
      end
   endtask

   // drive away from the edge, then sample just after the capturing edge
   task automatic step(logic ld, logic [W-1:0] st, logic advn);
      @(negedge clk);
      load_i  = ld;
      start_i = st;
      adv_ni  = advn;
      @(posedge clk);
      #1;
   endtask

   task automatic t_reset();
      check("R1 during reset", 0, 0);
      @(negedge clk);
      rst_ni = 1'b1;
      step(0, 0, 1);
      check("R1 after release", 0, 0);
   endtask

   task automatic t_linear();
      ilv_i = 1'b0;
      step(1, 3, 1);  check("R2 load 3 linear", 3, 0);
      step(0, 0, 0);  check("R5 linear beat1", 0, 1);
      step(0, 0, 0);  check("R5 linear beat2", 1, 2);
      step(0, 0, 0);  check("R3 linear beat3", 2, 3);
      step(0, 0, 0);  check("R8 linear wrap", 3, 0);
   endtask

   task automatic t_interleave();
      ilv_i = 1'b1;
      step(1, 2, 1);  check("R2 load 2 xor", 2, 0);
      step(0, 0, 0);  check("R6 xor beat1", 3, 1);
      step(0, 0, 0);  check("R6 xor beat2", 0, 2);
      step(0, 0, 0);  check("R6 xor beat3", 1, 3);
      step(0, 0, 0);  check("R8 xor wrap", 2, 0);
   endtask

   task automatic t_wait();
      ilv_i = 1'b0;
      step(1, 1, 1);  check("R2 load 1", 1, 0);
      step(0, 0, 0);  check("R3 advance", 2, 1);
      for (int i = 0; i < 3; i++) begin
         step(0, 3, 1);  check("R4 wait hold", 2, 1);
      end
      step(0, 0, 0);  check("R4 resume after wait", 3, 2);
   endtask

   task automatic t_priority();
      step(1, 0, 0);  check("R7 load beats advance", 0, 0);
      step(0, 0, 0);  check("R7 advance after load", 1, 1);
   endtask

   task automatic t_sweep();
      for (int m = 0; m < 2; m++) begin
         for (int s = 0; s < 4; s++) begin
            ilv_i = m[0];
            step(1, W'(s), 1);
            check("R2 sweep load", W'(s), 0);
            for (int b = 1; b <= 4; b++) begin
               logic [W-1:0] eb;
               logic [W-1:0] ea;
               eb = W'(b);
               ea = (m == 1) ? (W'(s) ^ eb) : W'(s + b);
               step(0, W'(b), 0);
               if (b == 4)      check("R8 sweep wrap", ea, eb);
               else if (m == 1) check("R6 sweep", ea, eb);
               else             check("R5 sweep", ea, eb);
            end
         end
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      t_reset();
      t_linear();
      t_interleave();
      t_wait();
      t_priority();
      t_sweep();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      #(4 * 20000);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule